// File: doc/BRIEF.md
# UART Transmit Byte Queue with Watermark

This block is the transmit-side byte queue of a memory-mapped UART. Software stores bytes by writing a data register; a downstream serializer takes one byte each time it signals readiness, but only while transmission is enabled. The queue tracks its fill level, keeps full and empty indications, and exposes the level in a readable register.

Two event signals go to the interrupt logic. The watermark flag rises when a store leaves the level at or above a programmable threshold, and falls when a removal takes the level below it. The empty event is a one-cycle pulse issued when the serializer takes the last stored byte. A software flush bit discards all queued bytes at once.

Register offsets: 0x0C control, 0x10 status, 0x18 write data, 0x1C queue control, 0x20 queue status. All reads are combinational on `reg_addr_i`.

Top module: `uart_txq`

## Requirements
- R1: Bytes written to offset 0x18 (data in bits 7:0) leave on `ser_data_o` in write order, one per cycle in which `ser_valid_o` and `ser_ready_i` are both high; the queue holds up to 16 bytes.
- R2: A write to offset 0x18 while the level is 16 is discarded and the level stays 16.
- R3: `ser_valid_o` is high only while bit 0 of offset 0x0C (transmit enable) is 1 and the level is non-zero; with the enable at 0 no byte is removed.
- R4: Offset 0x20 bits 4:0 read the level; it changes in the cycle after a store or removal, and a store and removal in the same cycle leave it unchanged.
- R5: Offset 0x10 bit 0 reads 1 exactly when the level is 16 and returns to 0 once a removal drops the level below 16.
- R6: Offset 0x10 bit 2 reads 1 after reset and after a flush, is cleared by any store, and is set again when a removal brings the level to zero.
- R7: `evt_tx_empty_o` pulses high for one cycle, the cycle after the removal that empties the queue; a flush produces no pulse.
- R8: Offset 0x1C bits 6:5 hold the threshold W (0 to 3). `evt_tx_watermark_o` is set when a store leaves level >= W, cleared when a removal leaves level < W, and otherwise holds its value.
- R9: Writing offset 0x1C with bit 1 set discards all queued bytes: the level becomes 0, status bit 2 sets, the watermark flag clears, and bit 1 reads back as 0.
- R10: After reset the level is 0, the status reads 0x4, offsets 0x0C and 0x1C read 0, and both event outputs and `ser_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| ser_ready_i | input | 1 | Serializer can accept a byte |
| ser_valid_o | output | 1 | Head byte is offered to the serializer |
| ser_data_o | output | 8 | Head byte |
| evt_tx_watermark_o | output | 1 | Watermark event flag |
| evt_tx_empty_o | output | 1 | One-cycle pulse when the queue drains empty |

## Verification
Stores, removals and flushes update the level, status bits and watermark flag at the rising edge where the strobe is seen, so their results are due one cycle later, while register reads and the head byte follow the address and state combinationally within the same cycle. The empty pulse is due in the cycle after the final removal and lasts exactly one cycle. The bench drives every input on the falling edge, reads registers shortly after it, and its scoreboard monitor samples the handshake just before the next rising edge, so each check sees the state one edge after its stimulus.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned WM_W   = 2;

  localparam logic [REG_AW-1:0] OFS_CTRL     = 6'h0C;
  localparam logic [REG_AW-1:0] OFS_STATUS   = 6'h10;
  localparam logic [REG_AW-1:0] OFS_WDATA    = 6'h18;
  localparam logic [REG_AW-1:0] OFS_QCTRL    = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_QSTATUS  = 6'h20;

  localparam int unsigned CTRL_TXEN_BIT = 0;
  localparam int unsigned ST_FULL_BIT   = 0;
  localparam int unsigned ST_EMPTY_BIT  = 2;
  localparam int unsigned QC_FLUSH_BIT  = 1;
  localparam int unsigned QC_WM_LSB     = 5;
endpackage

// File: rtl/uart_txq_regs.sv
module uart_txq_regs import uart_txq_pkg::*; #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LVL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic              full_i,
  input  logic              empty_i,
  input  logic [LVL_W-1:0]  level_i,
  output logic              tx_en_o,
  output logic [WM_W-1:0]   wm_lvl_o,
  output logic              push_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] push_data_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[REG_DW-1:DATA_W];

  logic wr_ctrl, wr_qctrl;
  assign wr_ctrl  = we_i && (addr_i == OFS_CTRL);
  assign wr_qctrl = we_i && (addr_i == OFS_QCTRL);

  // stores into a full queue are dropped here
  assign push_o      = we_i && (addr_i == OFS_WDATA) && !full_i;
  assign flush_o     = wr_qctrl && wdata_i[QC_FLUSH_BIT];
  assign push_data_o = wdata_i[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_o  <= 1'b0;
      wm_lvl_o <= '0;
    end else begin
      if (wr_ctrl)  tx_en_o  <= wdata_i[CTRL_TXEN_BIT];
      if (wr_qctrl) wm_lvl_o <= wdata_i[QC_WM_LSB +: WM_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL:    rdata_o[CTRL_TXEN_BIT] = tx_en_o;
      OFS_STATUS: begin
        rdata_o[ST_FULL_BIT]  = full_i;
        rdata_o[ST_EMPTY_BIT] = empty_i;
      end
      OFS_QCTRL:   rdata_o[QC_WM_LSB +: WM_W] = wm_lvl_o;
      OFS_QSTATUS: rdata_o[LVL_W-1:0] = level_i;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              flush_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (push_i && !flush_i && (wr_ptr_q == PTR_W'(i))) begin
        mem_q[i] <= wdata_i;
      end
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/uart_txq_level.sv
module uart_txq_level import uart_txq_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic [WM_W-1:0]  wm_lvl_i,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             wm_evt_o,
  output logic             empty_evt_o
);
  logic [LVL_W-1:0] lvl_nxt;
  logic [LVL_W-1:0] wm_ext;
  assign wm_ext = {{(LVL_W-WM_W){1'b0}}, wm_lvl_i};

  always_comb begin
    if (flush_i) begin
      lvl_nxt = '0;
    end else begin
      unique case ({push_i, pop_i})
        2'b10:   lvl_nxt = level_o + LVL_W'(1);
        2'b01:   lvl_nxt = level_o - LVL_W'(1);
        default: lvl_nxt = level_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o     <= '0;
      empty_o     <= 1'b1;
      wm_evt_o    <= 1'b0;
      empty_evt_o <= 1'b0;
    end else begin
      level_o     <= lvl_nxt;
      empty_evt_o <= 1'b0;
      if (flush_i) begin
        empty_o  <= 1'b1;
        wm_evt_o <= 1'b0;
      end else begin
        if (push_i) begin
          empty_o <= 1'b0;
        end else if (pop_i && lvl_nxt == '0) begin
          empty_o     <= 1'b1;
          empty_evt_o <= 1'b1;
        end
        // push takes precedence: with push and pop together the level holds
        if (push_i && lvl_nxt >= wm_ext)     wm_evt_o <= 1'b1;
        else if (pop_i && lvl_nxt < wm_ext)  wm_evt_o <= 1'b0;
      end
    end
  end

  assign full_o = (level_o == LVL_W'(DEPTH));
endmodule

// File: rtl/uart_txq.sv
module uart_txq import uart_txq_pkg::*; #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              ser_ready_i,
  output logic              ser_valid_o,
  output logic [DATA_W-1:0] ser_data_o,
  output logic              evt_tx_watermark_o,
  output logic              evt_tx_empty_o
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic              tx_en, tx_full, tx_empty;
  logic              push_w, pop_w, flush_w;
  logic [WM_W-1:0]   wm_lvl;
  logic [LVL_W-1:0]  level;
  logic [DATA_W-1:0] push_data;

  // a flush in progress hides the head byte from the serializer
  assign ser_valid_o = tx_en && !tx_empty && !flush_w;
  assign pop_w       = ser_valid_o && ser_ready_i;

  uart_txq_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .full_i      (tx_full),
    .empty_i     (tx_empty),
    .level_i     (level),
    .tx_en_o     (tx_en),
    .wm_lvl_o    (wm_lvl),
    .push_o      (push_w),
    .flush_o     (flush_w),
    .push_data_o (push_data)
  );

  uart_txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .pop_i   (pop_w),
    .flush_i (flush_w),
    .wdata_i (push_data),
    .rdata_o (ser_data_o)
  );

  uart_txq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_w),
    .pop_i       (pop_w),
    .flush_i     (flush_w),
    .wm_lvl_i    (wm_lvl),
    .level_o     (level),
    .full_o      (tx_full),
    .empty_o     (tx_empty),
    .wm_evt_o    (evt_tx_watermark_o),
    .empty_evt_o (evt_tx_empty_o)
  );
endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk import uart_txq_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LVL_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              ser_valid_o,
  input logic              evt_tx_watermark_o,
  input logic              evt_tx_empty_o,
  input logic              tx_en,
  input logic              tx_empty,
  input logic              push_w,
  input logic              pop_w,
  input logic              flush_w,
  input logic [WM_W-1:0]   wm_lvl,
  input logic [LVL_W-1:0]  level
);
  int unsigned lvl_i, wm_i;
  assign lvl_i = int'(level);
  assign wm_i  = int'(wm_lvl);

  assert_full_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == OFS_WDATA && lvl_i == DEPTH && !pop_w) |=> (lvl_i == DEPTH));

  assert_valid_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_valid_o |-> (tx_en && lvl_i != 0));

  assert_level_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i <= DEPTH);

  assert_pushpop_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_w && pop_w && !flush_w) |=> $stable(level));

  assert_empty_track_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty == (lvl_i == 0));

  assert_empty_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_tx_empty_o |-> (lvl_i == 0 && $past(pop_w)));

  assert_wm_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_w && !pop_w && !flush_w && lvl_i + 1 >= wm_i) |=> evt_tx_watermark_o);

  assert_wm_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_w && !push_w && !flush_w && lvl_i - 1 < wm_i) |=> !evt_tx_watermark_o);

  assert_flush_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_w |=> (lvl_i == 0 && tx_empty && !evt_tx_watermark_o && !evt_tx_empty_o));
endmodule

bind uart_txq uart_txq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i              (clk_i),
  .rst_ni             (rst_ni),
  .reg_we_i           (reg_we_i),
  .reg_addr_i         (reg_addr_i),
  .ser_valid_o        (ser_valid_o),
  .evt_tx_watermark_o (evt_tx_watermark_o),
  .evt_tx_empty_o     (evt_tx_empty_o),
  .tx_en              (tx_en),
  .tx_empty           (tx_empty),
  .push_w             (push_w),
  .pop_w              (pop_w),
  .flush_w            (flush_w),
  .wm_lvl             (wm_lvl),
  .level              (level)
);

// File: tb/uart_txq_tb.sv
`timescale 1ns/100ps
module uart_txq_tb;
  localparam logic [5:0] A_CTRL = 6'h0C, A_STAT = 6'h10, A_WDATA = 6'h18,
                         A_QCTRL = 6'h1C, A_QSTAT = 6'h20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        ser_ready_i = 1'b0;
  logic        ser_valid_o;
  logic [7:0]  ser_data_o;
  logic        evt_tx_watermark_o, evt_tx_empty_o;

  int checks = 0, errors = 0, empty_pulses = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  uart_txq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .ser_ready_i(ser_ready_i),
    .ser_valid_o(ser_valid_o), .ser_data_o(ser_data_o),
    .evt_tx_watermark_o(evt_tx_watermark_o), .evt_tx_empty_o(evt_tx_empty_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  // driver: store a byte and record it when the model has room
  task automatic push(input logic [7:0] b);
    wr(A_WDATA, {24'h0, b});
    if (exp_q.size() < 16) exp_q.push_back(b);
  endtask

  task automatic drain(input int n);
    @(negedge clk);
    ser_ready_i = 1'b1;
    repeat (n) @(negedge clk);
    ser_ready_i = 1'b0;
  endtask

  // monitor: compare each handshake against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_ni && ser_valid_o && ser_ready_i) begin
        if (exp_q.size() == 0) check("R1 unexpected byte", {24'h0, ser_data_o}, 32'hFFFF_FFFF);
        else check("R1 byte order", {24'h0, ser_data_o}, {24'h0, exp_q.pop_front()});
      end
      if (rst_ni && evt_tx_empty_o) empty_pulses++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 reset state
    rd(A_STAT, v);  check("R10 status after reset", v, 32'h4);
    rd(A_QSTAT, v); check("R10 level after reset", v, 32'h0);
    rd(A_QCTRL, v); check("R10 queue ctrl after reset", v, 32'h0);
    rd(A_CTRL, v);  check("R10 ctrl after reset", v, 32'h0);
    check("R10 valid low", {31'h0, ser_valid_o}, 32'h0);
    check("R10 watermark low", {31'h0, evt_tx_watermark_o}, 32'h0);

    // R8 threshold 2
    wr(A_QCTRL, 32'h40);
    push(8'h11);
    rd(A_QSTAT, v); check("R4 level 1", v, 32'h1);
    check("R8 below threshold", {31'h0, evt_tx_watermark_o}, 32'h0);
    rd(A_STAT, v);  check("R6 empty cleared by store", v, 32'h0);
    push(8'h22);
    check("R8 reached threshold", {31'h0, evt_tx_watermark_o}, 32'h1);

    for (int i = 0; i < 14; i++) push(8'h30 + 8'(i));
    rd(A_QSTAT, v); check("R1 level 16", v, 32'h10);
    rd(A_STAT, v);  check("R5 full set", v, 32'h1);
    push(8'hEE);
    rd(A_QSTAT, v); check("R2 store dropped when full", v, 32'h10);

    // R3 disabled: no removal
    drain(3);
    rd(A_QSTAT, v); check("R3 no drain while disabled", v, 32'h10);
    check("R3 valid low while disabled", {31'h0, ser_valid_o}, 32'h0);

    wr(A_CTRL, 32'h1);
    rd(A_CTRL, v);  check("R3 enable reads back", v, 32'h1);
    drain(1);
    rd(A_QSTAT, v); check("R4 level 15", v, 32'hF);
    rd(A_STAT, v);  check("R5 full cleared", v, 32'h0);
    drain(13);
    rd(A_QSTAT, v); check("R4 level 2", v, 32'h2);
    check("R8 held at threshold", {31'h0, evt_tx_watermark_o}, 32'h1);
    drain(1);
    check("R8 cleared below threshold", {31'h0, evt_tx_watermark_o}, 32'h0);
    check("R7 no pulse yet", empty_pulses, 0);
    drain(1);
    rd(A_STAT, v);  check("R6 empty set on last removal", v, 32'h4);
    check("R7 one pulse", empty_pulses, 1);
    check("R1 scoreboard drained", exp_q.size(), 0);

    // R4 simultaneous store and removal
    push(8'h51);
    push(8'h52);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = A_WDATA; reg_wdata_i = 32'h53; ser_ready_i = 1'b1;
    exp_q.push_back(8'h53);
    @(negedge clk);
    reg_we_i = 1'b0; ser_ready_i = 1'b0;
    rd(A_QSTAT, v); check("R4 store+removal keeps level", v, 32'h2);
    check("R8 flag after store+removal", {31'h0, evt_tx_watermark_o}, 32'h1);

    // R9 flush
    wr(A_QCTRL, 32'h42);
    exp_q.delete();
    rd(A_QSTAT, v); check("R9 level zero after flush", v, 32'h0);
    rd(A_STAT, v);  check("R9 empty after flush", v, 32'h4);
    check("R9 watermark cleared", {31'h0, evt_tx_watermark_o}, 32'h0);
    rd(A_QCTRL, v); check("R9 flush bit self-clears", v, 32'h40);
    check("R7 no pulse on flush", empty_pulses, 1);
    push(8'h77);
    drain(1);
    rd(A_QSTAT, v); check("R1 post-flush byte sent", v, 32'h0);
    check("R7 second pulse", empty_pulses, 2);

    // R8 threshold 0
    wr(A_CTRL, 32'h0);
    wr(A_QCTRL, 32'h0);
    push(8'h01);
    check("R8 threshold zero sets", {31'h0, evt_tx_watermark_o}, 32'h1);
    wr(A_CTRL, 32'h1);
    drain(1);
    check("R8 threshold zero holds on drain", {31'h0, evt_tx_watermark_o}, 32'h1);
    check("R1 final scoreboard", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule